// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the memory-mapped control register file of a PCI host bridge. A simple 32-bit register bus (address, write data, write strobe, read strobe, registered read data) reaches four groups of registers. There are three address-translation words, twelve bus-control words, eight interrupt-routing words and one reset-control word. Only the low 16 address bits are decoded. Every address outside the implemented words reads as zero, and writes to such addresses are dropped.

Each group applies its own write rule. Translation and bus-control words take the whole write. An interrupt-routing word lets only its enable bit (bit 31) change. The reset-control word mixes write-one-to-clear and write-one-to-set bits. Writing it can issue a one-cycle soft power-on or soft external reset request to the system reset logic.

A separate system reset input (`sys_rst_i`) stands for each reset the system applies after power-up. That reset disables every interrupt route. It reloads the reset-control word with only the power-on flag, but only when this is the first reset since a soft power-on request.

Top module: `hb_ctrl_regs`

## Requirements
- R1: After `rst_ni` is released: routing word i (read at 0xC04 + 8*i) reads `(0x1F << 6) | (i << 2)`; reset-control reads 0x80000000; translation and bus-control words read 0; both request outputs are low.
- R2: Translation words sit at 0x0200, 0x0204 and 0x0208, selected by address bits [3:2]. Each stores and returns all 32 bits of a write.
- R3: Bus-control words sit at 0x2000 through 0x202C, selected by address bits [5:2]. Each stores and returns all 32 bits of a write.
- R4: Routing word i sits at 0xC04 + 8*i. A write changes only bit 31; bits [30:0] keep their value. The companion word at 0xC00 + 8*i reads 0 and ignores writes.
- R5: Reset-control sits at 0xF024, and 0xF020 reads 0 and ignores writes. A write is first masked with 0xF8000000. After masking, set bits 31, 28 and 27 clear those register bits, and set bits 30 and 29 set those register bits. Bits [26:0] always read 0.
- R6: A reset-control write with bit 30 set drives `soft_por_req_o` high for the single cycle after the write. It does not drive `soft_xir_req_o`. It marks the next system reset as a first reset.
- R7: A reset-control write with bit 29 set and bit 30 clear drives `soft_xir_req_o` high for the single cycle after the write. It does not mark the next system reset as a first reset.
- R8: A `sys_rst_i` cycle clears bit 31 of every routing word and keeps bits [30:0]. On the first such reset after a soft power-on request, reset-control becomes exactly 0x80000000. Any other system reset leaves reset-control unchanged.
- R9: The ranges 0x0030–0x004F and 0x020C–0x03FF, and every other address that is not an implemented word, read 0. Writes to these addresses change no register. Address bits above bit 15 do not affect decoding.
- R10: Read data is captured at the clock edge where `rd_en_i` is high, so it appears one cycle after the strobe. It holds its value until the next read.
- R11: While `sys_rst_i` is high, bus writes change no register and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up initialisation, active low |
| sys_rst_i | input | 1 | System reset cycle applied after power-up |
| addr_i | input | 32 | Byte address; bits [15:0] decoded |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| soft_por_req_o | output | 1 | One-cycle soft power-on reset request |
| soft_xir_req_o | output | 1 | One-cycle soft external reset request |

## Verification
The hardest state to reach is the first-reset memory. It only shows its effect on a later `sys_rst_i` cycle. By then the reset-control word has been changed by several writes, and whether it reloads depends on which kind of soft request came last. The bench therefore chains several steps: a soft external request, a clear of the power-on flag, a soft power-on request, and then a system reset. It reads reset-control after each step. It then repeats the chain with only an external request before the reset, to show that the word is left alone. Sweeps across each window and its neighbouring addresses, first reading and then writing address-dependent patterns, cover decoding and the per-window write rules.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic [2:0] {
      WIN_NONE  = 3'd0,
      WIN_XLAT  = 3'd1,
      WIN_BCTL  = 3'd2,
      WIN_ROUTE = 3'd3,
      WIN_RSTC  = 3'd4
   } hbr_win_e;

   localparam logic [15:0] XLAT_LO  = 16'h0200;
   localparam logic [15:0] XLAT_HI  = 16'h020B;
   localparam logic [15:0] BCTL_LO  = 16'h2000;
   localparam logic [15:0] BCTL_HI  = 16'h202F;
   localparam logic [15:0] ROUTE_LO = 16'h0C00;
   localparam logic [15:0] ROUTE_HI = 16'h0C3F;
   localparam logic [15:0] RSTC_LO  = 16'hF020;
   localparam logic [15:0] RSTC_HI  = 16'hF027;

   localparam logic [31:0] RSTC_KEEP = 32'hF800_0000;
   localparam logic [31:0] RSTC_W1C  = 32'h9800_0000;
   localparam logic [31:0] RSTC_W1S  = 32'h6000_0000;
   localparam logic [31:0] RSTC_PWR  = 32'h8000_0000;
   localparam int          SPOR_BIT  = 30;
   localparam int          SXIR_BIT  = 29;
   localparam int          ROUTE_EN  = 31;

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
#(
   parameter int N_XLAT  = 3,
   parameter int N_BCTL  = 12,
   parameter int N_ROUTE = 8,
   parameter int IW      = 4
) (
   input  logic [15:0]   a_i,
   output hbr_win_e      win_o,
   output logic [IW-1:0] idx_o
);
   localparam logic [IW-1:0] LIM_XLAT  = IW'(N_XLAT);
   localparam logic [IW-1:0] LIM_BCTL  = IW'(N_BCTL);
   localparam logic [IW-1:0] LIM_ROUTE = IW'(N_ROUTE);

   logic [IW-1:0] ix_xlat, ix_bctl, ix_route;

   assign ix_xlat  = IW'(a_i[3:2]);
   assign ix_bctl  = IW'(a_i[5:2]);
   assign ix_route = IW'(a_i[5:3]);

   always_comb begin
      win_o = WIN_NONE;
      idx_o = '0;
      if (a_i >= XLAT_LO && a_i <= XLAT_HI && ix_xlat < LIM_XLAT) begin
         win_o = WIN_XLAT;
         idx_o = ix_xlat;
      end else if (a_i >= BCTL_LO && a_i <= BCTL_HI && ix_bctl < LIM_BCTL) begin
         win_o = WIN_BCTL;
         idx_o = ix_bctl;
      end else if (a_i >= ROUTE_LO && a_i <= ROUTE_HI && a_i[2] && ix_route < LIM_ROUTE) begin
         win_o = WIN_ROUTE;
         idx_o = ix_route;
      end else if (a_i >= RSTC_LO && a_i <= RSTC_HI && a_i[2]) begin
         win_o = WIN_RSTC;
      end
   end
endmodule

// File: rtl/hbr_rw_bank.sv
module hbr_rw_bank #(
   parameter int N  = 3,
   parameter int DW = 32,
   parameter int IW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [IW-1:0] idx_i,
   input  logic [DW-1:0] wdata_i,
   output logic [N*DW-1:0] words_o
);
   for (genvar g = 0; g < N; g++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            words_o[g*DW +: DW] <= '0;
         else if (we_i && idx_i == IW'(g))
            words_o[g*DW +: DW] <= wdata_i;
      end
   end
endmodule

// File: rtl/hbr_route_bank.sv
module hbr_route_bank #(
   parameter int N  = 8,
   parameter int DW = 32,
   parameter int IW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_en_i,
   input  logic          we_i,
   input  logic [IW-1:0] idx_i,
   input  logic          en_bit_i,
   output logic [N*DW-1:0] words_o
);
   for (genvar g = 0; g < N; g++) begin : g_route
      localparam logic [DW-2:0] INIT_LO = (DW-1)'((32'h1F << 6) | (g << 2));
      logic          en_q;
      logic [DW-2:0] lo_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q <= 1'b0;
            lo_q <= INIT_LO;
         end else if (clr_en_i) begin
            en_q <= 1'b0;
         end else if (we_i && idx_i == IW'(g)) begin
            en_q <= en_bit_i;
         end
      end

      assign words_o[g*DW +: DW] = {en_q, lo_q};
   end
endmodule

// File: rtl/hbr_rst_ctrl.sv
module hbr_rst_ctrl
   import hbr_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        sys_rst_i,
   input  logic        we_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rstc_o,
   output logic        por_req_o,
   output logic        xir_req_o
);
   logic [31:0] val;
   logic        first_q;

   assign val = wdata_i & RSTC_KEEP;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rstc_o    <= RSTC_PWR;
         first_q   <= 1'b0;
         por_req_o <= 1'b0;
         xir_req_o <= 1'b0;
      end else if (sys_rst_i) begin
         por_req_o <= 1'b0;
         xir_req_o <= 1'b0;
         if (first_q) begin
            rstc_o  <= RSTC_PWR;
            first_q <= 1'b0;
         end
      end else if (we_i) begin
         rstc_o    <= (rstc_o & ~(val & RSTC_W1C)) | (val & RSTC_W1S);
         por_req_o <= val[SPOR_BIT];
         xir_req_o <= val[SXIR_BIT] & ~val[SPOR_BIT];
         if (val[SPOR_BIT])
            first_q <= 1'b1;
      end else begin
         por_req_o <= 1'b0;
         xir_req_o <= 1'b0;
      end
   end
endmodule

// File: rtl/hb_ctrl_regs.sv
module hb_ctrl_regs
   import hbr_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int N_XLAT  = 3,
   parameter int N_BCTL  = 12,
   parameter int N_ROUTE = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sys_rst_i,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          rd_en_i,
   output logic [DW-1:0] rdata_o,
   output logic          soft_por_req_o,
   output logic          soft_xir_req_o
);
   localparam int IW = 4;

   if (DW != 32) begin : g_bad_dw
      $error("hb_ctrl_regs: DW must be 32");
   end
   if (AW < 16) begin : g_bad_aw
      $error("hb_ctrl_regs: AW must be at least 16");
   end
   if (N_XLAT < 1 || N_XLAT > 3) begin : g_bad_xlat
      $error("hb_ctrl_regs: N_XLAT must be 1..3");
   end
   if (N_BCTL < 1 || N_BCTL > 12) begin : g_bad_bctl
      $error("hb_ctrl_regs: N_BCTL must be 1..12");
   end
   if (N_ROUTE < 1 || N_ROUTE > 8) begin : g_bad_route
      $error("hb_ctrl_regs: N_ROUTE must be 1..8");
   end

   hbr_win_e          win;
   logic [IW-1:0]     idx;
   logic              wr_ok;
   logic [N_XLAT*DW-1:0]  xlat_w;
   logic [N_BCTL*DW-1:0]  bctl_w;
   logic [N_ROUTE*DW-1:0] route_w;
   logic [31:0]       rstc_w;
   logic [DW-1:0]     rd_word;
   logic              unused_hi;

   if (AW > 16) begin : g_hi
      assign unused_hi = ^addr_i[AW-1:16];
   end else begin : g_nohi
      assign unused_hi = 1'b0;
   end

   assign wr_ok = wr_en_i & ~sys_rst_i;

   hbr_decode #(
      .N_XLAT(N_XLAT), .N_BCTL(N_BCTL), .N_ROUTE(N_ROUTE), .IW(IW)
   ) u_dec (
      .a_i(addr_i[15:0]), .win_o(win), .idx_o(idx)
   );

   hbr_rw_bank #(.N(N_XLAT), .DW(DW), .IW(IW)) u_xlat (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && win == WIN_XLAT),
      .idx_i(idx), .wdata_i(wdata_i), .words_o(xlat_w)
   );

   hbr_rw_bank #(.N(N_BCTL), .DW(DW), .IW(IW)) u_bctl (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && win == WIN_BCTL),
      .idx_i(idx), .wdata_i(wdata_i), .words_o(bctl_w)
   );

   hbr_route_bank #(.N(N_ROUTE), .DW(DW), .IW(IW)) u_route (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_en_i(sys_rst_i),
      .we_i(wr_ok && win == WIN_ROUTE), .idx_i(idx),
      .en_bit_i(wdata_i[ROUTE_EN]), .words_o(route_w)
   );

   hbr_rst_ctrl u_rstc (
      .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i),
      .we_i(wr_ok && win == WIN_RSTC), .wdata_i(wdata_i),
      .rstc_o(rstc_w), .por_req_o(soft_por_req_o), .xir_req_o(soft_xir_req_o)
   );

   always_comb begin
      rd_word = '0;
      unique case (win)
         WIN_XLAT:
            for (int i = 0; i < N_XLAT; i++)
               if (idx == IW'(i)) rd_word = xlat_w[i*DW +: DW];
         WIN_BCTL:
            for (int i = 0; i < N_BCTL; i++)
               if (idx == IW'(i)) rd_word = bctl_w[i*DW +: DW];
         WIN_ROUTE:
            for (int i = 0; i < N_ROUTE; i++)
               if (idx == IW'(i)) rd_word = route_w[i*DW +: DW];
         WIN_RSTC:
            rd_word = rstc_w;
         default:
            rd_word = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         rdata_o <= '0;
      else if (rd_en_i)
         rdata_o <= rd_word;
   end
endmodule

// File: rtl/hbr_regs_chk.sv
module hbr_regs_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        sys_rst_i,
   input logic [15:0] addr_lo,
   input logic        wr_en_i,
   input logic        spor_bit,
   input logic        sxir_bit,
   input logic        rd_en_i,
   input logic [31:0] rdata_o,
   input logic        por_req,
   input logic        xir_req
);
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(por_req && xir_req)); // R6

   AST_POR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_req |-> $past(wr_en_i && !sys_rst_i && addr_lo == 16'hF024 && spor_bit)); // R6

   AST_XIR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xir_req |-> $past(wr_en_i && !sys_rst_i && addr_lo == 16'hF024 && sxir_bit && !spor_bit)); // R7

   AST_LOW_RANGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_lo < 16'h0200) |=> rdata_o == 32'h0); // R9

   AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o)); // R10

   AST_NO_REQ_IN_SYSRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_i |=> !por_req && !xir_req); // R11
endmodule

bind hb_ctrl_regs hbr_regs_chk u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i),
   .addr_lo(addr_i[15:0]), .wr_en_i(wr_en_i),
   .spor_bit(wdata_i[30]), .sxir_bit(wdata_i[29]),
   .rd_en_i(rd_en_i), .rdata_o(rdata_o),
   .por_req(soft_por_req_o), .xir_req(soft_xir_req_o)
);

// File: tb/tb_hb_ctrl_regs.sv
module tb_hb_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        sys_rst_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic        rd_en_i = 1'b0;
   logic [31:0] rdata_o;
   logic        soft_por_req_o, soft_xir_req_o;

   int n_chk = 0, n_bad = 0;

   logic [31:0] m_xlat [3];
   logic [31:0] m_bctl [12];
   logic [31:0] m_route[8];
   logic [31:0] m_rc;
   bit          m_first;
   logic        p_por, p_xir, q_por, q_xir;

   always #5 clk = ~clk;

   hb_ctrl_regs dut (
      .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .addr_i(addr_i),
      .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
      .soft_por_req_o(soft_por_req_o), .soft_xir_req_o(soft_xir_req_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [15:0] a);
      if (a >= 16'h0200 && a <= 16'h020B) return m_xlat[a[3:2]];
      if (a >= 16'h2000 && a <= 16'h202F) return m_bctl[a[5:2]];
      if (a >= 16'h0C00 && a <= 16'h0C3F && a[2]) return m_route[a[5:3]];
      if (a == 16'hF024) return m_rc;
      return 32'h0;
   endfunction

   task automatic mdl_wr(input logic [15:0] a, input logic [31:0] d);
      logic [31:0] v;
      if (a >= 16'h0200 && a <= 16'h020B) m_xlat[a[3:2]] = d;
      else if (a >= 16'h2000 && a <= 16'h202F) m_bctl[a[5:2]] = d;
      else if (a >= 16'h0C00 && a <= 16'h0C3F && a[2])
         m_route[a[5:3]] = {d[31], m_route[a[5:3]][30:0]};
      else if (a == 16'hF024) begin
         v = d & 32'hF800_0000;
         m_rc = (m_rc & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
         if (v[30]) m_first = 1'b1;
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
      p_por = soft_por_req_o; p_xir = soft_xir_req_o;
      @(negedge clk);
      q_por = soft_por_req_o; q_xir = soft_xir_req_o;
      if (!sys_rst_i) mdl_wr(a[15:0], d);
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      addr_i = a; rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      d = rdata_o;
   endtask

   task automatic mdl_sysrst();
      for (int i = 0; i < 8; i++) m_route[i][31] = 1'b0;
      if (m_first) begin m_rc = 32'h8000_0000; m_first = 1'b0; end
   endtask

   task automatic sysrst();
      @(negedge clk); sys_rst_i = 1'b1;
      @(negedge clk); sys_rst_i = 1'b0;
      mdl_sysrst();
   endtask

   task automatic sweep_rd(input string req, input logic [15:0] base, input int len);
      logic [31:0] d;
      for (int o = 0; o < len; o += 4) begin
         rd({16'h0000, base + 16'(o)}, d);
         chk(req, d, exp_rd(base + 16'(o)));
      end
   endtask

   task automatic sweep_wr(input logic [15:0] base, input int len);
      logic [15:0] a;
      for (int o = 0; o < len; o += 4) begin
         a = base + 16'(o);
         if (!(a >= 16'hF020 && a <= 16'hF027))
            wr({16'h0000, a}, {a, ~a} ^ 32'hC3A5_0F96);
      end
   endtask

   task automatic sweep_all(input string req);
      sweep_rd(req, 16'h0000, 16'h60);
      sweep_rd(req, 16'h01F0, 16'h220);
      sweep_rd(req, 16'h0BF0, 16'h60);
      sweep_rd(req, 16'h1FF0, 16'h50);
      sweep_rd(req, 16'hEFF0, 16'h40);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, d0;
      for (int i = 0; i < 3; i++) m_xlat[i] = '0;
      for (int i = 0; i < 12; i++) m_bctl[i] = '0;
      for (int i = 0; i < 8; i++) m_route[i] = 32'h7C0 | 32'(i << 2);
      m_rc = 32'h8000_0000; m_first = 1'b0;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 por_req", {31'b0, soft_por_req_o}, 32'h0);
      chk("R1 xir_req", {31'b0, soft_xir_req_o}, 32'h0);
      for (int i = 0; i < 8; i++) begin
         rd(32'h0C04 + 32'(8 * i), d);
         chk("R1 route init", d, 32'h7C0 | 32'(i << 2));
      end
      rd(32'hF024, d); chk("R1 rstc init", d, 32'h8000_0000);
      sweep_all("R9 R1 initial sweep");

      // R2 R3 R4 R9 write sweeps then readback
      sweep_wr(16'h0000, 16'h60);
      sweep_wr(16'h01F0, 16'h220);
      sweep_wr(16'h0BF0, 16'h60);
      sweep_wr(16'h1FF0, 16'h50);
      sweep_wr(16'hEFF0, 16'h40);
      sweep_all("R2 R3 R4 R9 sweep after writes");
      rd(32'h0000_0204, d); chk("R2 xlat word1", d, {16'h0204, 16'hFDFB} ^ 32'hC3A5_0F96);
      rd(32'h0000_2028, d); chk("R3 bctl word10", d, {16'h2028, 16'hDFD7} ^ 32'hC3A5_0F96);

      // R9 upper address bits ignored
      wr(32'h5A5A_0208, 32'h1357_9BDF);
      rd(32'h0000_0208, d); chk("R9 alias write", d, 32'h1357_9BDF);
      rd(32'hFFFF_2000, d); chk("R9 alias read", d, m_bctl[0]);

      // R4 enable toggles, low bits fixed
      wr(32'h0C14, 32'h8000_0000);
      rd(32'h0C14, d); chk("R4 enable set", d, 32'h8000_0000 | 32'h7C0 | 32'h8);
      wr(32'h0C14, 32'h7FFF_FFFF);
      rd(32'h0C14, d); chk("R4 enable clr", d, 32'h7C0 | 32'h8);
      wr(32'h0C10, 32'hFFFF_FFFF);
      rd(32'h0C10, d); chk("R4 even word", d, 32'h0);

      // R5 reset-control masking
      wr(32'hF020, 32'hFFFF_FFFF);
      rd(32'hF020, d); chk("R5 F020 zero", d, 32'h0);
      rd(32'hF024, d); chk("R5 F020 ignored", d, 32'h8000_0000);
      wr(32'hF024, 32'h2000_0000);
      chk("R7 xir pulse", {30'b0, p_xir, p_por}, 32'h2);
      chk("R7 xir one cycle", {30'b0, q_xir, q_por}, 32'h0);
      rd(32'hF024, d); chk("R5 w1s bit29", d, 32'hA000_0000);
      wr(32'hF024, 32'h8000_0000);
      rd(32'hF024, d); chk("R5 w1c bit31", d, 32'h2000_0000);
      wr(32'hF024, 32'h6000_0000);
      chk("R6 por pulse only", {30'b0, p_xir, p_por}, 32'h1);
      chk("R6 por one cycle", {30'b0, q_xir, q_por}, 32'h0);
      wr(32'hF024, 32'h9FFF_FFFF);
      chk("R6 no req", {30'b0, p_xir, p_por}, 32'h0);
      rd(32'hF024, d); chk("R5 low bits zero", d, 32'h6000_0000);

      // R8 first reset after soft POR
      wr(32'h0C04, 32'h8000_0000);
      wr(32'h0C3C, 32'h8000_0000);
      sysrst();
      rd(32'hF024, d); chk("R8 first reset reload", d, 32'h8000_0000);
      rd(32'h0C04, d); chk("R8 enable cleared 0", d, 32'h7C0);
      rd(32'h0C3C, d); chk("R8 enable cleared 7", d, 32'h7C0 | 32'h1C);
      wr(32'h0C24, 32'h8000_0000);
      wr(32'hF024, 32'h2000_0000);
      sysrst();
      rd(32'hF024, d); chk("R8 later reset keeps", d, 32'hA000_0000);
      rd(32'h0C24, d); chk("R8 enable cleared 4", d, 32'h7C0 | 32'h10);

      // R11 writes blocked during system reset
      @(negedge clk);
      sys_rst_i = 1'b1; wr_en_i = 1'b1; addr_i = 32'h0200; wdata_i = 32'hDEAD_BEEF;
      @(negedge clk);
      addr_i = 32'hF024; wdata_i = 32'h4000_0000;
      @(negedge clk);
      chk("R11 no por", {31'b0, soft_por_req_o}, 32'h0);
      sys_rst_i = 1'b0; wr_en_i = 1'b0;
      mdl_sysrst();
      @(negedge clk);
      chk("R11 no por later", {31'b0, soft_por_req_o}, 32'h0);
      rd(32'h0200, d); chk("R11 xlat kept", d, m_xlat[0]);
      rd(32'hF024, d); chk("R11 rstc kept", d, 32'hA000_0000);

      // R10 read data holds without strobe
      rd(32'h2004, d0);
      wr(32'h2004, 32'h0BAD_F00D);
      repeat (3) @(negedge clk);
      chk("R10 hold", rdata_o, d0);
      rd(32'h2004, d); chk("R10 new read", d, 32'h0BAD_F00D);
      rd(32'h0030, d); chk("R9 dma range", d, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule